// File: doc/BRIEF.md
# Security Attribution Configuration Register Bank

This block holds the software-visible configuration of a security attribution unit: an enable/control pair, a read-only count of implemented address regions, a region selector, per-region base and limit words, a fault status word and a fault address word. It decodes seven word registers in a small window of a 32-bit register bus. Every transfer carries a secure/non-secure attribute. Only secure transfers can see or change the bank.

The region table and control bits are driven to downstream lookup logic as flat vectors. An invalidate strobe tells any cached translation state to flush whenever a region word changes. Fault detection logic sets status bits through a dedicated set input, and software clears them by writing ones.

Each request is accepted in one cycle. Its response (valid, read data, error) appears in the following cycle. Register updates take effect at the edge that samples the request.

Top module: `secattr_cfg_bank`

## Requirements
- R1: The byte offsets are 0xDD0 control, 0xDD4 type, 0xDD8 region select, 0xDDC region base, 0xDE0 region limit, 0xDE4 fault status and 0xDE8 fault address. Any other offset, including misaligned ones, gives `rsp_err_o`=1 with read data 0 and changes no state.
- R2: A non-secure read of any register in the window returns 0 with `rsp_err_o`=0. A non-secure write to any register in the window changes nothing and raises no strobe.
- R3: A secure write to control stores only bits [1:0], and those bits drive `ctrl_o`. Bits [31:2] read as 0.
- R4: The type register reads the region-count parameter `NREG`, and writes to it have no effect.
- R5: A secure write of a value below `NREG` to the region select register stores it, and it reads back. A value of `NREG` or more is dropped, the old selection is kept, and `sel_err_o` pulses high for one cycle in the response cycle.
- R6: Base and limit accesses reach only the selected region. A read or write of a region that is not implemented returns 0 or is ignored. Region r drives bits [32r+31:32r] of `region_base_o` and `region_limit_o`.
- R7: A base write stores the data with bits [4:0] cleared. A limit write stores the data with bits [4:2] cleared, and limit bits [1:0] stay writable.
- R8: A secure write to fault status clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R9: Each 1 on `fault_set_i` sets that status bit at the next edge. A set wins over a software clear of the same bit in the same cycle.
- R10: A secure write to fault address stores all 32 bits and does not change fault status.
- R11: `inval_o` is high for exactly the response cycle of each accepted secure base or limit write. It stays low for all other transfers.
- R12: After reset, every register and output is 0, except the type register, which reads `NREG`.
- R13: `rsp_valid_o` is high in the cycle after each request and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_secure_i | input | 1 | 1 = secure transfer |
| req_addr_i | input | ADDR_W | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | 32 | Read data (0 for writes and refused reads) |
| rsp_err_o | output | 1 | Offset outside the decoded window |
| fault_set_i | input | 32 | Hardware set mask for fault status |
| ctrl_o | output | 2 | Control bits |
| region_base_o | output | 32*NREG | Base words, region 0 in the low bits |
| region_limit_o | output | 32*NREG | Limit words, region 0 in the low bits |
| inval_o | output | 1 | One-cycle flush strobe after a region change |
| sel_err_o | output | 1 | One-cycle strobe for a rejected region select |
| fault_status_o | output | 32 | Fault status word |
| fault_addr_o | output | 32 | Fault address word |

## Verification
A wrong internal state shows up in two places: on the region and control output vectors at the edge after the faulty update, and in the read data one cycle after the next read of the register concerned. A corrupted region select shows only indirectly: base and limit traffic lands in the wrong slice of the flat outputs, so the bench checks every slice after every region write. Leaks through the security gate are caught by reading back through a secure access right after each non-secure write. The set/clear race on fault status is decided at a single edge, so it is probed in the exact cycle of the collision.

// File: rtl/secattr_cfg_pkg.sv
package secattr_cfg_pkg;

   localparam int unsigned DATA_W = 32;

   // byte offsets of the decoded window
   localparam logic [11:0] OFS_CTRL   = 12'hDD0;
   localparam logic [11:0] OFS_TYPE   = 12'hDD4;
   localparam logic [11:0] OFS_SELECT = 12'hDD8;
   localparam logic [11:0] OFS_BASE   = 12'hDDC;
   localparam logic [11:0] OFS_LIMIT  = 12'hDE0;
   localparam logic [11:0] OFS_FSTAT  = 12'hDE4;
   localparam logic [11:0] OFS_FADDR  = 12'hDE8;

   // bits cleared on region writes
   localparam logic [DATA_W-1:0] BASE_CLR_BITS  = 32'h0000_001F;
   localparam logic [DATA_W-1:0] LIMIT_CLR_BITS = 32'h0000_001C;

   localparam int unsigned CTRL_W = 2;

   typedef enum logic [2:0] {
      SEL_CTRL   = 3'd0,
      SEL_TYPE   = 3'd1,
      SEL_SELECT = 3'd2,
      SEL_BASE   = 3'd3,
      SEL_LIMIT  = 3'd4,
      SEL_FSTAT  = 3'd5,
      SEL_FADDR  = 3'd6,
      SEL_NONE   = 3'd7
   } reg_sel_e;

endpackage

// File: rtl/secattr_decode.sv
module secattr_decode
   import secattr_cfg_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);

   generate
      if (ADDR_W < 12) begin : g_bad_width
         $error("secattr_decode: ADDR_W must be at least 12");
      end
   endgenerate

   always_comb begin
      sel_o = SEL_NONE;
      if      (addr_i == ADDR_W'(OFS_CTRL))   sel_o = SEL_CTRL;
      else if (addr_i == ADDR_W'(OFS_TYPE))   sel_o = SEL_TYPE;
      else if (addr_i == ADDR_W'(OFS_SELECT)) sel_o = SEL_SELECT;
      else if (addr_i == ADDR_W'(OFS_BASE))   sel_o = SEL_BASE;
      else if (addr_i == ADDR_W'(OFS_LIMIT))  sel_o = SEL_LIMIT;
      else if (addr_i == ADDR_W'(OFS_FSTAT))  sel_o = SEL_FSTAT;
      else if (addr_i == ADDR_W'(OFS_FADDR))  sel_o = SEL_FADDR;
   end

endmodule

// File: rtl/secattr_region_file.sv
module secattr_region_file
   import secattr_cfg_pkg::*;
#(
   parameter int unsigned NREG  = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [IDX_W-1:0]         idx_i,
   input  logic                     base_we_i,
   input  logic                     limit_we_i,
   input  logic [DATA_W-1:0]        wdata_i,
   output logic                     idx_ok_o,
   output logic [DATA_W-1:0]        base_rd_o,
   output logic [DATA_W-1:0]        limit_rd_o,
   output logic [NREG*DATA_W-1:0]   base_flat_o,
   output logic [NREG*DATA_W-1:0]   limit_flat_o
);

   localparam logic [DATA_W-1:0] BASE_KEEP  = ~BASE_CLR_BITS;
   localparam logic [DATA_W-1:0] LIMIT_KEEP = ~LIMIT_CLR_BITS;

   generate
      if (NREG < 1) begin : g_bad_count
         $error("secattr_region_file: NREG must be at least 1");
      end
      if ((1 << IDX_W) < NREG) begin : g_bad_idx
         $error("secattr_region_file: IDX_W too narrow for NREG");
      end
   endgenerate

   logic [DATA_W-1:0] base_q  [NREG];
   logic [DATA_W-1:0] limit_q [NREG];

   assign idx_ok_o = (32'(idx_i) < NREG);

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_region
         logic hit;
         assign hit = idx_ok_o && (32'(idx_i) == g);

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               base_q[g]  <= '0;
               limit_q[g] <= '0;
            end else begin
               if (base_we_i && hit)  base_q[g]  <= wdata_i & BASE_KEEP;
               if (limit_we_i && hit) limit_q[g] <= wdata_i & LIMIT_KEEP;
            end
         end

         assign base_flat_o[g*DATA_W +: DATA_W]  = base_q[g];
         assign limit_flat_o[g*DATA_W +: DATA_W] = limit_q[g];
      end
   endgenerate

   always_comb begin
      base_rd_o  = '0;
      limit_rd_o = '0;
      for (int r = 0; r < NREG; r++) begin
         if (idx_ok_o && 32'(idx_i) == r) begin
            base_rd_o  = base_q[r];
            limit_rd_o = limit_q[r];
         end
      end
   end

   // R6
   bad_idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((base_we_i || limit_we_i) && !idx_ok_o) |=> ($stable(base_flat_o) && $stable(limit_flat_o)));

   // R6
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!base_we_i && !limit_we_i) |=> ($stable(base_flat_o) && $stable(limit_flat_o)));

endmodule

// File: rtl/secattr_fault_regs.sv
module secattr_fault_regs
   import secattr_cfg_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_we_i,
   input  logic [DATA_W-1:0] clr_mask_i,
   input  logic              addr_we_i,
   input  logic [DATA_W-1:0] addr_wdata_i,
   input  logic [DATA_W-1:0] set_i,
   output logic [DATA_W-1:0] status_o,
   output logic [DATA_W-1:0] addr_o
);

   logic [DATA_W-1:0] status_q, addr_q, clr_eff;

   assign clr_eff = clr_we_i ? clr_mask_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         status_q <= '0;
         addr_q   <= '0;
      end else begin
         status_q <= (status_q & ~clr_eff) | set_i;
         if (addr_we_i) addr_q <= addr_wdata_i;
      end
   end

   assign status_o = status_q;
   assign addr_o   = addr_q;

   // R9
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

   // R8
   w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && set_i == '0) |=> ((status_o & $past(clr_mask_i)) == '0));

   // R10
   addr_keeps_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_we_i && !clr_we_i && set_i == '0) |=> $stable(status_o));

endmodule

// File: rtl/secattr_cfg_bank.sv
module secattr_cfg_bank
   import secattr_cfg_pkg::*;
#(
   parameter int unsigned NREG   = 4,
   parameter int unsigned ADDR_W = 12
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   req_valid_i,
   input  logic                   req_write_i,
   input  logic                   req_secure_i,
   input  logic [ADDR_W-1:0]      req_addr_i,
   input  logic [31:0]            req_wdata_i,
   output logic                   rsp_valid_o,
   output logic [31:0]            rsp_rdata_o,
   output logic                   rsp_err_o,
   input  logic [31:0]            fault_set_i,
   output logic [1:0]             ctrl_o,
   output logic [NREG*32-1:0]     region_base_o,
   output logic [NREG*32-1:0]     region_limit_o,
   output logic                   inval_o,
   output logic                   sel_err_o,
   output logic [31:0]            fault_status_o,
   output logic [31:0]            fault_addr_o
);

   localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

   generate
      if (NREG < 1 || NREG > 255) begin : g_bad_nreg
         $error("secattr_cfg_bank: NREG must lie in 1..255");
      end
   endgenerate

   reg_sel_e           sel;
   logic               acc_ok, wr_ok, rd_ok;
   logic [CTRL_W-1:0]  ctrl_q;
   logic [IDX_W-1:0]   idx_q;
   logic               idx_ok;
   logic [DATA_W-1:0]  base_rd, limit_rd, rd_val;
   logic               base_we, limit_we, sel_wr, sel_fits;
   logic               rsp_valid_q, rsp_err_q, inval_q, sel_err_q, ns_rsp_q;
   logic [DATA_W-1:0]  rsp_rdata_q;

   secattr_decode #(.ADDR_W(ADDR_W)) decode_i (
      .addr_i (req_addr_i),
      .sel_o  (sel)
   );

   assign acc_ok   = req_valid_i && req_secure_i && (sel != SEL_NONE);
   assign wr_ok    = acc_ok && req_write_i;
   assign rd_ok    = acc_ok && !req_write_i;
   assign base_we  = wr_ok && (sel == SEL_BASE);
   assign limit_we = wr_ok && (sel == SEL_LIMIT);
   assign sel_wr   = wr_ok && (sel == SEL_SELECT);
   assign sel_fits = (req_wdata_i < 32'(NREG));

   secattr_region_file #(.NREG(NREG), .IDX_W(IDX_W)) regions_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .idx_i        (idx_q),
      .base_we_i    (base_we),
      .limit_we_i   (limit_we),
      .wdata_i      (req_wdata_i),
      .idx_ok_o     (idx_ok),
      .base_rd_o    (base_rd),
      .limit_rd_o   (limit_rd),
      .base_flat_o  (region_base_o),
      .limit_flat_o (region_limit_o)
   );

   secattr_fault_regs fault_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_we_i     (wr_ok && (sel == SEL_FSTAT)),
      .clr_mask_i   (req_wdata_i),
      .addr_we_i    (wr_ok && (sel == SEL_FADDR)),
      .addr_wdata_i (req_wdata_i),
      .set_i        (fault_set_i),
      .status_o     (fault_status_o),
      .addr_o       (fault_addr_o)
   );

   // control and region selector
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         idx_q  <= '0;
      end else begin
         if (wr_ok && sel == SEL_CTRL) ctrl_q <= req_wdata_i[CTRL_W-1:0];
         if (sel_wr && sel_fits)       idx_q  <= req_wdata_i[IDX_W-1:0];
      end
   end

   assign ctrl_o = ctrl_q;

   always_comb begin
      unique case (sel)
         SEL_CTRL:   rd_val = DATA_W'(ctrl_q);
         SEL_TYPE:   rd_val = DATA_W'(NREG);
         SEL_SELECT: rd_val = DATA_W'(idx_q);
         SEL_BASE:   rd_val = idx_ok ? base_rd : '0;
         SEL_LIMIT:  rd_val = idx_ok ? limit_rd : '0;
         SEL_FSTAT:  rd_val = fault_status_o;
         SEL_FADDR:  rd_val = fault_addr_o;
         default:    rd_val = '0;
      endcase
   end

   // response stage and strobes
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_q <= 1'b0;
         rsp_err_q   <= 1'b0;
         rsp_rdata_q <= '0;
         inval_q     <= 1'b0;
         sel_err_q   <= 1'b0;
         ns_rsp_q    <= 1'b0;
      end else begin
         rsp_valid_q <= req_valid_i;
         rsp_err_q   <= req_valid_i && (sel == SEL_NONE);
         rsp_rdata_q <= rd_ok ? rd_val : '0;
         inval_q     <= (base_we || limit_we) && idx_ok;
         sel_err_q   <= sel_wr && !sel_fits;
         ns_rsp_q    <= req_valid_i && !req_secure_i;
      end
   end

   assign rsp_valid_o = rsp_valid_q;
   assign rsp_err_o   = rsp_err_q;
   assign rsp_rdata_o = rsp_rdata_q;
   assign inval_o     = inval_q;
   assign sel_err_o   = sel_err_q;

   // R2
   ns_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_write_i && !req_secure_i && fault_set_i == '0)
      |=> ($stable(ctrl_o) && $stable(region_base_o) && $stable(region_limit_o)
           && $stable(fault_addr_o) && $stable(fault_status_o) && !inval_o && !sel_err_o));

   // R2
   ns_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && ns_rsp_q) |-> (rsp_rdata_o == '0));

   // R1
   bad_offset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_err_o |-> (rsp_rdata_o == '0 && !inval_o && !sel_err_o));

   // R5
   sel_err_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_err_o |-> $stable(idx_q));

   // R11
   inval_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inval_o |-> $past(req_valid_i && req_write_i && req_secure_i));

   // R13
   rsp_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> rsp_valid_o);

   // R13
   rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> !rsp_valid_o);

endmodule

// File: tb/secattr_cfg_bank_tb.sv
module secattr_cfg_bank_tb_top;

   localparam int unsigned NREG = 3;
   localparam time HALF = 4ns;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
   logic [11:0]       req_addr = '0;
   logic [31:0]       req_wdata = '0;
   logic              rsp_valid, rsp_err, inval, sel_err;
   logic [31:0]       rsp_rdata, fstat, faddr;
   logic [31:0]       fault_set = '0;
   logic [1:0]        ctrl;
   logic [NREG*32-1:0] rbase, rlimit;

   int checks = 0;
   int errors = 0;

   logic        c_err, c_inval, c_selerr, c_valid;
   logic [31:0] c_data;

   logic [31:0] exp_base  [NREG];
   logic [31:0] exp_limit [NREG];

   always #HALF clk = ~clk;

   secattr_cfg_bank #(.NREG(NREG), .ADDR_W(12)) dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .req_valid_i    (req_valid),
      .req_write_i    (req_write),
      .req_secure_i   (req_secure),
      .req_addr_i     (req_addr),
      .req_wdata_i    (req_wdata),
      .rsp_valid_o    (rsp_valid),
      .rsp_rdata_o    (rsp_rdata),
      .rsp_err_o      (rsp_err),
      .fault_set_i    (fault_set),
      .ctrl_o         (ctrl),
      .region_base_o  (rbase),
      .region_limit_o (rlimit),
      .inval_o        (inval),
      .sel_err_o      (sel_err),
      .fault_status_o (fstat),
      .fault_addr_o   (faddr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic s, input logic [31:0] setm);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_secure = s; req_addr = a; req_wdata = d;
      fault_set = setm;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; fault_set = '0;
      c_valid = rsp_valid; c_err = rsp_err; c_data = rsp_rdata;
      c_inval = inval; c_selerr = sel_err;
   endtask

   task automatic wr32(input logic [11:0] a, input logic [31:0] d, input logic s);
      xfer(1'b1, a, d, s, 32'h0);
   endtask

   task automatic rd32(input logic [11:0] a, input logic s);
      xfer(1'b0, a, 32'h0, s, 32'h0);
   endtask

   task automatic chk_regions(input string tag);
      for (int r = 0; r < NREG; r++) begin
         chk(tag, rbase[r*32 +: 32], exp_base[r]);
         chk(tag, rlimit[r*32 +: 32], exp_limit[r]);
      end
   endtask

   initial begin : watchdog
      #(HALF * 2 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [11:0] win [7];
      logic [1:0]  cur_sel;
      win = '{12'hDD0, 12'hDD4, 12'hDD8, 12'hDDC, 12'hDE0, 12'hDE4, 12'hDE8};
      for (int r = 0; r < NREG; r++) begin exp_base[r] = '0; exp_limit[r] = '0; end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 ctrl", 32'(ctrl), 32'h0);
      chk("R12 fstat", fstat, 32'h0);
      chk("R12 faddr", faddr, 32'h0);
      chk("R12 strobes", {30'h0, inval, sel_err}, 32'h0);
      chk_regions("R12 regions");
      rd32(12'hDD4, 1'b1);
      chk("R12 type", c_data, 32'(NREG));
      chk("R13 rsp valid", 32'(c_valid), 32'h1);
      @(negedge clk);
      chk("R13 rsp idle", 32'(rsp_valid), 32'h0);

      // R4 type is read-only
      wr32(12'hDD4, 32'hFFFF_FFFF, 1'b1);
      rd32(12'hDD4, 1'b1);
      chk("R4 type after write", c_data, 32'(NREG));

      // R3 control masking
      wr32(12'hDD0, 32'hFFFF_FFFF, 1'b1);
      chk("R3 ctrl_o", 32'(ctrl), 32'h3);
      rd32(12'hDD0, 1'b1);
      chk("R3 ctrl read", c_data, 32'h3);
      wr32(12'hDD0, 32'h1234_5676, 1'b1);
      rd32(12'hDD0, 1'b1);
      chk("R3 ctrl read2", c_data, 32'h2);

      // R5 selector sweep with range check
      cur_sel = 2'd0;
      for (int v = 0; v < 6; v++) begin
         wr32(12'hDD8, 32'(v), 1'b1);
         chk("R5 sel_err", 32'(c_selerr), (v >= NREG) ? 32'h1 : 32'h0);
         if (v < NREG) cur_sel = 2'(v);
         @(negedge clk);
         chk("R5 sel_err one cycle", 32'(sel_err), 32'h0);
         rd32(12'hDD8, 1'b1);
         chk("R5 sel readback", c_data, 32'(cur_sel));
      end
      wr32(12'hDD8, 32'h8000_0001, 1'b1);
      chk("R5 huge value err", 32'(c_selerr), 32'h1);
      rd32(12'hDD8, 1'b1);
      chk("R5 huge value kept", c_data, 32'(cur_sel));

      // R6 R7 R11 region writes through the selector
      for (int r = 0; r < NREG; r++) begin
         logic [31:0] bv, lv;
         bv = 32'hA5A5_A5FF ^ (32'(r) << 12);
         lv = 32'h5A5A_5AFF ^ (32'(r) << 16);
         wr32(12'hDD8, 32'(r), 1'b1);
         chk("R11 no inval on select", 32'(c_inval), 32'h0);
         wr32(12'hDDC, bv, 1'b1);
         chk("R11 inval base", 32'(c_inval), 32'h1);
         @(negedge clk);
         chk("R11 inval one cycle", 32'(inval), 32'h0);
         wr32(12'hDE0, lv, 1'b1);
         chk("R11 inval limit", 32'(c_inval), 32'h1);
         exp_base[r]  = bv & ~32'h1F;
         exp_limit[r] = lv & ~32'h1C;
         chk_regions("R6 region outputs");
         rd32(12'hDDC, 1'b1);
         chk("R7 base read", c_data, exp_base[r]);
         rd32(12'hDE0, 1'b1);
         chk("R7 limit read", c_data, exp_limit[r]);
      end
      // R7 limit low bits writable
      wr32(12'hDE0, 32'h0000_0003, 1'b1);
      exp_limit[NREG-1] = 32'h3;
      rd32(12'hDE0, 1'b1);
      chk("R7 limit low bits", c_data, 32'h3);

      // R2 non-secure writes ignored
      wr32(12'hDDC, 32'hFFFF_FFFF, 1'b0);
      chk("R2 ns base no inval", 32'(c_inval), 32'h0);
      wr32(12'hDD0, 32'h0, 1'b0);
      wr32(12'hDE8, 32'h1111_1111, 1'b0);
      wr32(12'hDD8, 32'h7, 1'b0);
      chk("R2 ns select no err", 32'(c_selerr), 32'h0);
      chk("R2 ctrl kept", 32'(ctrl), 32'h2);
      chk("R2 faddr kept", faddr, 32'h0);
      chk_regions("R2 regions kept");
      // R2 non-secure reads see zero
      for (int i = 0; i < 7; i++) begin
         rd32(win[i], 1'b0);
         chk("R2 ns read data", c_data, 32'h0);
         chk("R2 ns read err", 32'(c_err), 32'h0);
      end

      // R1 bad offsets
      begin
         logic [11:0] bad [5];
         bad = '{12'hDCC, 12'hDEC, 12'hDD1, 12'hDE6, 12'h000};
         for (int i = 0; i < 5; i++) begin
            rd32(bad[i], 1'b1);
            chk("R1 bad err", 32'(c_err), 32'h1);
            chk("R1 bad data", c_data, 32'h0);
         end
         wr32(12'hDD2, 32'h0, 1'b1);
         chk("R1 bad write err", 32'(c_err), 32'h1);
         chk("R1 ctrl unchanged", 32'(ctrl), 32'h2);
         for (int i = 0; i < 7; i++) begin
            rd32(win[i], 1'b1);
            chk("R1 window no err", 32'(c_err), 32'h0);
         end
      end

      // R8 R9 fault status
      xfer(1'b0, 12'h000, 32'h0, 1'b1, 32'hF0F0_00FF);
      chk("R9 set", fstat, 32'hF0F0_00FF);
      wr32(12'hDE4, 32'h0000_000F, 1'b1);
      chk("R8 w1c", fstat, 32'hF0F0_00F0);
      wr32(12'hDE4, 32'h0000_0000, 1'b1);
      chk("R8 zeros keep", fstat, 32'hF0F0_00F0);
      xfer(1'b1, 12'hDE4, 32'h0000_0030, 1'b1, 32'h0000_0010);
      chk("R9 set beats clear", fstat, 32'hF0F0_00D0);
      rd32(12'hDE4, 1'b1);
      chk("R8 fstat read", c_data, 32'hF0F0_00D0);
      wr32(12'hDE4, 32'hFFFF_FFFF, 1'b0);
      chk("R2 ns w1c ignored", fstat, 32'hF0F0_00D0);

      // R10 fault address
      wr32(12'hDE8, 32'hDEAD_BEEF, 1'b1);
      chk("R10 faddr", faddr, 32'hDEAD_BEEF);
      chk("R10 fstat untouched", fstat, 32'hF0F0_00D0);
      rd32(12'hDE8, 1'b1);
      chk("R10 faddr read", c_data, 32'hDEAD_BEEF);
      wr32(12'hDE4, 32'hFFFF_FFFF, 1'b1);
      chk("R8 clear all", fstat, 32'h0);
      chk("R10 faddr after clear", faddr, 32'hDEAD_BEEF);
      chk_regions("R6 final regions");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule